// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus, of the SMBus style, that gives a host controller access to a small bank of 8-bit configuration registers. The host can write or read one indexed register, or it can move a run of registers in one transaction. A run always starts at register 0 and moves upward. The registers come up with default values at reset, so a system that keeps the defaults never has to use the bus.

The bus lines are sampled by a faster system clock through a two-stage synchroniser. START and STOP conditions, and the edges of the serial clock, are found from the sampled lines. The slave never drives SDA high. It pulls SDA low by raising `sda_oe`, so the pad is open drain. The register contents are presented in parallel on `cfg` for the logic that uses them.

The most significant bit of the command byte selects the kind of transfer. A 1 means a single-register access, and the lower seven bits give the register index. A 0 means a run. A write run normally carries a byte count after the command; raising `skip_count` removes that count byte. A read run always sends the count first.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `cfg` holds the default contents: register i sits in `cfg[8i+7:8i]`, and register 0 is 78h, 1 is 69h, 2 is 5Ah, 3 is 4Bh, 4 is 3Ch, 5 is 2Dh, 6 is 1Eh and 7 is 0Fh. `sda_oe` is low.
- R2: The slave acknowledges only the 7-bit address 69h. An acknowledge means SDA is pulled low in the ninth clock slot, and the first byte after START is therefore D2h for a write or D3h for a read. For any other address the slave leaves SDA released for the rest of the transaction, and no register changes.
- R3: When command bit 7 is 1, a write stores the next byte into the register whose index is given by command bits 6:0.
- R4: A single-register read works as follows. The host sends the write address and a command with bit 7 set, then a repeated START and the read address. The slave then returns that register, MSB first.
- R5: When command bit 7 is 0 and `skip_count` is low, a write treats the first byte after the command as a count. That count is acknowledged and has no other effect. Each following byte goes to registers 0, 1, 2 and upward.
- R6: When `skip_count` is high, a run write stores the first byte after the command into register 0, and each later byte into the next register.
- R7: A run read first returns the count 08h, then registers 0, 1 and upward while the host acknowledges. After the host's not-acknowledge, the slave releases SDA.
- R8: Bytes written past register 7, in a run or to a single index of 8 or above, are acknowledged and discarded.
- R9: A STOP in the middle of a byte leaves every completed write in place and drops the partial byte. The slave then answers the next transaction normally.
- R10: A read of an index past register 7 returns FFh.
- R11: The slave starts pulling SDA low only while SCL is low, and the register bank changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; loads the defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| skip_count | input | 1 | When high, run writes carry no count byte |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| cfg | output | 64 | Register bank, register i at bits 8i+7:8i |

## Verification
The case that is hardest to reach from the ports is a STOP that arrives partway through a data byte, after earlier bytes of the same run have already been stored. The stimulus handles it in three steps. It sends a complete run prefix and then only four data bits. It then lifts SDA while SCL is high. Finally, it opens a fresh single-register read, which shows through the normal read path that the finished byte landed and the partial one did not. A second hard case is the read cursor running past the bank, and a ten-byte run read reaches it. Throughout all of this, a behavioural copy of the bank is compared with `cfg` on every clock where SCL is high.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int           NREG     = 8,
  parameter logic [6:0]   DEV_ADDR = 7'h69,
  parameter logic [8*NREG-1:0] DEFAULTS = 64'h0F1E_2D3C_4B5A_6978
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              skip_count,
  output logic              sda_oe,
  output logic [8*NREG-1:0] cfg
);
  localparam int         AW       = $clog2(NREG);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic       ack_ph, rw, blk, mack;
  logic [7:0] sh, tx;
  logic [6:0] ptr;
  logic [7:0] regs [NREG];

  wire scl   = scl_s[1];
  wire sda   = sda_s[1];
  wire rise  = scl & ~scl_q;
  wire fall  = ~scl & scl_q;
  wire start = scl & scl_q & sda_q & ~sda;
  wire stop  = scl & scl_q & ~sda_q & sda;
  wire idle  = (st == S_IDLE);

  wire       in_range = int'(ptr) < NREG;
  wire [7:0] rd_byte  = in_range ? regs[ptr[AW-1:0]] : 8'hFF;
  wire [6:0] ptr_nx   = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
  wire       adr_ok   = (sh[7:1] == DEV_ADDR);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_q <= scl;               sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; ack_ph <= 1'b0; rw <= 1'b0; blk <= 1'b0;
      mack <= 1'b0; sh <= '0; tx <= '0; ptr <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= DEFAULTS[8*i +: 8];
    end else if (start) begin
      st <= S_ADDR; bitcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; ack_ph <= 1'b0; sda_oe <= 1'b0;
    end else if (st == S_RD) begin
      if (rise) begin
        if (ack_ph) mack <= ~sda;
        else        bitcnt <= bitcnt + 4'd1;
      end else if (fall) begin
        if (ack_ph) begin
          if (mack) begin
            tx <= rd_byte; sda_oe <= ~rd_byte[7]; ptr <= ptr_nx;
            bitcnt <= '0; ack_ph <= 1'b0;
          end else begin
            st <= S_IDLE; sda_oe <= 1'b0; ack_ph <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          sda_oe <= 1'b0; ack_ph <= 1'b1;
        end else if (bitcnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
        end
      end
    end else if (st != S_IDLE) begin
      if (rise && !ack_ph && bitcnt < 4'd8) begin
        sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 4'd1;
      end else if (fall) begin
        if (!ack_ph && bitcnt == 4'd8) begin
          ack_ph <= 1'b1; sda_oe <= 1'b1;
          case (st)
            S_ADDR: begin
              rw <= sh[0];
              if (!adr_ok) begin st <= S_IDLE; sda_oe <= 1'b0; ack_ph <= 1'b0; end
            end
            S_CMD: begin blk <= ~sh[7]; ptr <= sh[7] ? sh[6:0] : 7'd0; end
            S_WR: begin
              if (in_range) regs[ptr[AW-1:0]] <= sh;
              ptr <= ptr_nx;
            end
            default: ;
          endcase
        end else if (ack_ph) begin
          ack_ph <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
          case (st)
            S_ADDR: begin
              if (rw) begin
                st <= S_RD;
                if (blk) begin tx <= CNT_BYTE; sda_oe <= ~CNT_BYTE[7]; end
                else begin tx <= rd_byte; sda_oe <= ~rd_byte[7]; ptr <= ptr_nx; end
              end else st <= S_CMD;
            end
            S_CMD:   st <= (blk && !skip_count) ? S_CNT : S_WR;
            S_CNT:   st <= S_WR;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module smb_cfg_slave_chk #(
  parameter int NREG = 8,
  parameter logic [8*NREG-1:0] DEFAULTS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [8*NREG-1:0] cfg,
  input logic              idle
);
  p_defaults_r1: assert property (@(posedge clk) $rose(rst_n) |-> (cfg == DEFAULTS && !sda_oe));
  p_pull_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_i);
  p_write_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg) |-> !scl_i);
  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !sda_oe);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) idle |=> $stable(cfg));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg(cfg), .idle(idle)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/100ps
module tb_smb_cfg_slave;
  localparam int NREG = 8;
  localparam int Q    = 6;
  localparam logic [63:0] DEF = 64'h0F1E_2D3C_4B5A_6978;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, skip = 1'b0;
  logic cmp_en = 1'b0;
  wire sda_oe;
  wire [8*NREG-1:0] cfg;
  wire sda_bus = sda_m & ~sda_oe;
  int vectors = 0, fails = 0;
  logic [7:0] mdl [NREG];

  always #2.5 clk = ~clk;

  smb_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .skip_count(skip), .sda_oe(sda_oe), .cfg(cfg)
  );

  function automatic logic [63:0] mdl_flat();
    logic [63:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = mdl[i];
    return f;
  endfunction

  always @(negedge clk) begin
    if (cmp_en && scl_m) begin
      vectors++;
      if (cfg !== mdl_flat()) begin
        fails++;
        $display("FAIL R3/R5/R8 bank act=%h exp=%h", cfg, mdl_flat());
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2); b = sda_bus; tick(Q/2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, input int widx, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    if (widx >= 0 && widx < NREG) mdl[widx] = d;
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~give_ack);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] val, input string req);
    logic a;
    bus_start();
    wbyte(8'hD2, -1, a);            chk({req, " addr ack"}, {7'd0, a}, 8'd1);
    wbyte({1'b1, off}, -1, a);      chk({req, " cmd ack"}, {7'd0, a}, 8'd1);
    wbyte(val, int'(off), a);       chk({req, " data ack"}, {7'd0, a}, 8'd1);
    bus_stop();
  endtask

  task automatic byte_read(input logic [6:0] off, input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    bus_start();
    wbyte(8'hD2, -1, a);            chk({req, " addr ack"}, {7'd0, a}, 8'd1);
    wbyte({1'b1, off}, -1, a);      chk({req, " cmd ack"}, {7'd0, a}, 8'd1);
    bus_start();
    wbyte(8'hD3, -1, a);            chk({req, " raddr ack"}, {7'd0, a}, 8'd1);
    rbyte(1'b0, d);                 chk({req, " read data"}, d, exp);
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] d;
    for (int i = 0; i < NREG; i++) mdl[i] = DEF[8*i +: 8];
    tick(5);
    chk("R1 oe in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    tick(3);
    for (int i = 0; i < NREG; i++) chk("R1 default", cfg[8*i +: 8], DEF[8*i +: 8]);
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'd0);
    cmp_en = 1'b1;

    // R2: foreign address is ignored
    bus_start();
    wbyte(8'hA0, -1, a);           chk("R2 foreign addr nack", {7'd0, a}, 8'd0);
    wbyte(8'h83, -1, a);           chk("R2 no ack after nack", {7'd0, a}, 8'd0);
    wbyte(8'h55, -1, a);           chk("R2 no ack data", {7'd0, a}, 8'd0);
    bus_stop();

    // R3 / R4 single register
    byte_write(7'd5, 8'hC3, "R3");
    byte_read(7'd5, 8'hC3, "R4 reg5");
    byte_write(7'd0, 8'h81, "R3");
    byte_read(7'd0, 8'h81, "R4 reg0");
    byte_read(7'd2, mdl[2], "R4 reg2");

    // R8 single write out of range; R10 read out of range
    byte_write(7'd9, 8'h11, "R8");
    byte_read(7'd12, 8'hFF, "R10");

    // R5 run write with count, overflowing the bank (R8)
    bus_start();
    wbyte(8'hD2, -1, a);           chk("R5 addr ack", {7'd0, a}, 8'd1);
    wbyte(8'h00, -1, a);           chk("R5 cmd ack", {7'd0, a}, 8'd1);
    wbyte(8'd10, -1, a);           chk("R5 count ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < 10; i++) begin
      wbyte(8'hA0 + 8'(i), i, a);
      chk(i < NREG ? "R5 data ack" : "R8 overflow ack", {7'd0, a}, 8'd1);
    end
    bus_stop();

    // R7 and R10: run read returns count, bank, then FF
    bus_start();
    wbyte(8'hD2, -1, a);           chk("R7 addr ack", {7'd0, a}, 8'd1);
    wbyte(8'h00, -1, a);           chk("R7 cmd ack", {7'd0, a}, 8'd1);
    bus_start();
    wbyte(8'hD3, -1, a);           chk("R7 raddr ack", {7'd0, a}, 8'd1);
    rbyte(1'b1, d);                chk("R7 count", d, 8'd8);
    for (int i = 0; i < 10; i++) begin
      rbyte(i != 9, d);
      if (i < NREG) chk("R7 run data", d, mdl[i]);
      else          chk("R10 past end", d, 8'hFF);
    end
    tick(4);
    chk("R7 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();

    // R6 count skipped
    skip = 1'b1;
    bus_start();
    wbyte(8'hD2, -1, a);           chk("R6 addr ack", {7'd0, a}, 8'd1);
    wbyte(8'h00, -1, a);           chk("R6 cmd ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < 3; i++) begin
      wbyte(8'h30 + 8'(i), i, a);  chk("R6 data ack", {7'd0, a}, 8'd1);
    end
    bus_stop();
    skip = 1'b0;
    byte_read(7'd0, 8'h30, "R6 reg0");
    byte_read(7'd2, 8'h32, "R6 reg2");

    // R9 stop inside a byte
    bus_start();
    wbyte(8'hD2, -1, a);
    wbyte(8'h00, -1, a);
    wbyte(8'd2, -1, a);
    wbyte(8'h5E, 0, a);            chk("R9 first byte ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    byte_read(7'd0, 8'h5E, "R9 kept byte");
    byte_read(7'd1, mdl[1], "R9 partial dropped");

    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule